// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a successive-approximation converter that sits behind four track/hold stages, each fed from one of two input banks. Software programs a small control word over a parallel bus that chooses the bank, how many channels to convert per start, and whether the converter sleeps. An active-low start strobe then freezes all track/holds in the same cycle. The block converts the held channels one after another, always beginning with the first, and steers an external DAC and comparator through a bit-by-bit approximation for each one.

Each finished result is written as a 12-bit two's complement word into a small result store. After the last channel, the hold output drops back to tracking and an active-low interrupt falls. The host then drains the results with read strobes. A pointer steps through the store in a fixed order and wraps to the first channel, so the store cannot be addressed at random. All bus strobes are sampled on the block clock and their edges are found internally.

Top module: `sadc_seq`

## Requirements
- R1: After reset, intN is 1, holdOut is 0, busOe is 0 and pwrDown is 0. The mode is bank A with one channel per start. The result store has no defined contents.
- R2: The control word on busIn is taken when the write condition (csN low and wrN low) ends. Bits [1:0] hold the channel count minus one, bit 2 picks bank A (0) or B (1), and bit 3 set to 1 requests power-down.
- R3: A start is seen when cnvN rises. holdOut goes to 1 on the next clock, bankSel shows the bank of the programmed word, and chanSel runs 0, 1, 2, 3 up to the programmed count.
- R4: Each channel takes CONV_CYC clocks, 32 by default. holdOut falls and intN falls exactly N*CONV_CYC clocks after the clock that accepted the start, where N is the channel count.
- R5: A cnvN rising edge that arrives while a sequence is running has no effect. The length of the sequence and its results do not change.
- R6: A channel uses its last 12 clocks for approximation steps, deciding bit 11 first. During a step, dacCode is the bits decided so far with the trial bit set. cmpIn=1 keeps the trial bit. The stored result is the decided code with bit 11 inverted.
- R7: intN returns to 1 on the first clock where csN and rdN are both low after either was high. An accepted start also returns intN to 1.
- R8: The read pointer steps to the next channel when a read ends and wraps to channel 1 after four reads, whatever the channel count. An accepted start resets the pointer to channel 1, even if a read ends in the same clock. busOut shows the entry under the pointer.
- R9: While csN is 1, wrN and rdN pulses are ignored and busOe is 0.
- R10: While the power-down bit is set, pwrDown is 1 and starts are ignored. Writing a word with bit 3 at 0 wakes the block in the mode that word selects.
- R11: If a read begins in the same clock that the last conversion ends, intN still falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| cnvN | input | 1 | Active-low convert start; its rising edge triggers the sequence |
| busIn | input | 4 | Control word input |
| cmpIn | input | 1 | Comparator decision: 1 when the held input is at or above dacCode |
| busOut | output | 12 | Result word under the read pointer |
| busOe | output | 1 | Output enable for the data bus |
| dacCode | output | 12 | Trial code for the external DAC, in offset binary |
| holdOut | output | 1 | 1 holds all track/holds, 0 lets them track |
| bankSel | output | 1 | Input bank of the current sequence |
| chanSel | output | 2 | Channel currently being converted |
| intN | output | 1 | Active-low end-of-sequence interrupt |
| pwrDown | output | 1 | Power-down request to the analog section |

## Verification
Two pairs of events can land on the same clock. In the first, a read ends in the same cycle that a start is accepted. The bench releases rdN and cnvN on the same edge and expects the first read afterwards to return channel 1 of the new sequence. In the second, a read begins in the clock where the last channel finishes. The bench uses its own countdown to pull rdN low one clock before the sequence ends and expects intN to be low afterwards. A behavioural model checks every output on every clock, and it also catches a start that arrives during a sequence.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int STEP_W = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              clearSar;
    logic              stepEn;
    logic [STEP_W-1:0] stepBit;
    logic              storeEn;
  } seqStrobe_t;
endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 12,
  parameter int CONV_CYC = 32,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CW_W    = CH_W + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            wrN,
  input  logic            rdN,
  input  logic            cnvN,
  input  logic [CW_W-1:0] busIn,
  output seqStrobe_t      strobe,
  output logic [CH_W-1:0] chanIdx,
  output logic [CH_W-1:0] rdPtr,
  output logic            holdOut,
  output logic            bankSel,
  output logic            intN,
  output logic            pwrDown,
  output logic            busOe
);
  localparam int CNT_W  = $clog2(CONV_CYC + 1);
  localparam int SETTLE = CONV_CYC - DATA_W;

  initial begin
    if (SETTLE < 1) $error("CONV_CYC must exceed DATA_W");
  end

  // edge detection on the bus strobes
  logic wrActPrev, rdActPrev, cnvPrev;
  logic wrAct, rdAct, wrEnd, rdFall, rdRise, cnvRise;

  assign wrAct   = !csN && !wrN;
  assign rdAct   = !csN && !rdN;
  assign wrEnd   = wrActPrev && !wrAct;
  assign rdFall  = rdAct && !rdActPrev;
  assign rdRise  = rdActPrev && !rdAct;
  assign cnvRise = cnvN && !cnvPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActPrev <= 1'b0;
      rdActPrev <= 1'b0;
      cnvPrev   <= 1'b1;
    end else begin
      wrActPrev <= wrAct;
      rdActPrev <= rdAct;
      cnvPrev   <= cnvN;
    end
  end

  // mode register
  logic [CH_W-1:0] modeCnt;
  logic            modeBank;
  logic            modePd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCnt  <= '0;
      modeBank <= 1'b0;
      modePd   <= 1'b0;
    end else if (wrEnd) begin
      modeCnt  <= busIn[CH_W-1:0];
      modeBank <= busIn[CH_W];
      modePd   <= busIn[CH_W+1];
    end
  end

  // sequencer
  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  lastChan;
  logic             seqBank;
  logic             accept, chanDone, seqDone, conv;

  assign conv     = (state == ST_CONV);
  assign accept   = cnvRise && (state == ST_IDLE) && !modePd;
  assign chanDone = conv && (cnt == CNT_W'(CONV_CYC - 1));
  assign seqDone  = chanDone && (chanIdx == lastChan);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      chanIdx  <= '0;
      lastChan <= '0;
      seqBank  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_CONV;
            cnt      <= '0;
            chanIdx  <= '0;
            lastChan <= modeCnt;
            seqBank  <= modeBank;
          end
        end
        ST_CONV: begin
          if (seqDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (chanDone) begin
            cnt     <= '0;
            chanIdx <= chanIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // strobes towards the datapath
  logic [CNT_W-1:0] stepOff;
  assign stepOff = cnt - CNT_W'(SETTLE);

  always_comb begin
    strobe.clearSar = conv && (cnt == '0);
    strobe.stepEn   = conv && (cnt >= CNT_W'(SETTLE));
    strobe.stepBit  = STEP_W'(DATA_W - 1) - STEP_W'(stepOff);
    strobe.storeEn  = chanDone;
  end

  // read pointer and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      intN  <= 1'b1;
    end else begin
      if (accept)
        rdPtr <= '0;
      else if (rdRise)
        rdPtr <= (rdPtr == CH_W'(NUM_CH - 1)) ? '0 : rdPtr + 1'b1;

      if (seqDone)
        intN <= 1'b0;
      else if (accept || rdFall)
        intN <= 1'b1;
    end
  end

  assign holdOut = conv;
  assign bankSel = seqBank;
  assign pwrDown = modePd;
  assign busOe   = rdAct;

  AST_SEQ_FROM_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOut) |-> (chanIdx == '0)); // R3
  AST_INT_WITH_HOLD_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $fell(holdOut)); // R4
  AST_PD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOut) |-> !$past(modePd)); // R10
  AST_START_RESETS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOut) |-> (rdPtr == '0)); // R8
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    holdOut |-> (chanIdx <= lastChan)); // R5
endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmpIn,
  input  logic [CH_W-1:0]   chanIdx,
  input  logic [CH_W-1:0]   rdPtr,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] busOut
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sar, sarNext, bitMask;

  assign bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << strobe.stepBit;
  assign dacCode = strobe.stepEn ? (sar | bitMask) : sar;

  always_comb begin
    sarNext = sar;
    if (strobe.stepEn)
      sarNext = cmpIn ? (sar | bitMask) : (sar & ~bitMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sar <= '0;
    else if (strobe.clearSar)
      sar <= '0;
    else
      sar <= sarNext;
  end

  // result store, one slot per channel, no reset
  logic [DATA_W-1:0] slot [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.storeEn && (chanIdx == CH_W'(g)))
        slot[g] <= sarNext ^ MSB_MASK;
    end
  end

  assign busOut = slot[rdPtr];

  AST_SAR_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && strobe.stepBit == STEP_W'(DATA_W - 1)) |-> (sar == '0)); // R6
  AST_STORE_ON_LAST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |-> (strobe.stepEn && strobe.stepBit == '0)); // R6
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 12,
  parameter int CONV_CYC = 32,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CW_W    = CH_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              cnvN,
  input  logic [CW_W-1:0]   busIn,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] dacCode,
  output logic              holdOut,
  output logic              bankSel,
  output logic [CH_W-1:0]   chanSel,
  output logic              intN,
  output logic              pwrDown
);
  seqStrobe_t      strobe;
  logic [CH_W-1:0] rdPtr;

  sadc_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .cnvN(cnvN),
    .busIn(busIn), .strobe(strobe), .chanIdx(chanSel), .rdPtr(rdPtr),
    .holdOut(holdOut), .bankSel(bankSel), .intN(intN), .pwrDown(pwrDown),
    .busOe(busOe)
  );

  sadc_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .chanIdx(chanSel), .rdPtr(rdPtr), .dacCode(dacCode), .busOut(busOut)
  );

  AST_BUS_QUIET_NO_CS: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !busOe); // R9
endmodule

// File: tb/sadc_seq_test.sv
module sadc_seq_test;
  localparam int CONV = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1, cnvN = 1'b1;
  logic [3:0] busIn = '0;
  logic cmpIn;
  logic [11:0] busOut, dacCode;
  logic busOe, holdOut, bankSel, intN, pwrDown;
  logic [1:0] chanSel;

  int nChecks = 0;
  int nFails = 0;
  int analog [8];

  always #4 clk = ~clk;

  sadc_seq uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .cnvN(cnvN),
    .busIn(busIn), .cmpIn(cmpIn), .busOut(busOut), .busOe(busOe),
    .dacCode(dacCode), .holdOut(holdOut), .bankSel(bankSel),
    .chanSel(chanSel), .intN(intN), .pwrDown(pwrDown)
  );

  // comparator model: held input in offset binary vs trial code
  assign cmpIn = (analog[{bankSel, chanSel}] >= int'(dacCode));

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mCnt, mBank, mPd, busyLeft, mIntN, mHold, mPtr, seqN, seqBank;
  int res [4];
  bit valid [4];
  bit pWr, pRd, pCnv;

  always @(posedge clk) begin
    bit wrAct, rdAct, wrEnd, rdFall, rdRise, cnvRise, accept, endNow;
    if (!rstN) begin
      mCnt = 0; mBank = 0; mPd = 0; busyLeft = 0; mIntN = 1; mHold = 0;
      mPtr = 0; seqN = 1; seqBank = 0;
      for (int i = 0; i < 4; i++) valid[i] = 0;
      pWr = 0; pRd = 0; pCnv = 1;
    end else begin
      wrAct = !csN && !wrN;
      rdAct = !csN && !rdN;
      wrEnd = pWr && !wrAct;
      rdFall = rdAct && !pRd;
      rdRise = pRd && !rdAct;
      cnvRise = cnvN && !pCnv;
      accept = cnvRise && busyLeft == 0 && mPd == 0;
      endNow = 0;
      if (busyLeft > 0) begin
        busyLeft--;
        if (busyLeft == 0) endNow = 1;
      end
      if (endNow) begin
        for (int i = 0; i < seqN; i++) begin
          res[i] = analog[seqBank*4 + i] ^ 'h800;
          valid[i] = 1;
        end
        mHold = 0;
      end
      if (accept) begin
        seqN = mCnt + 1; seqBank = mBank; busyLeft = seqN * CONV; mHold = 1;
      end
      if (accept) mPtr = 0;
      else if (rdRise) mPtr = (mPtr + 1) % 4;
      if (endNow) mIntN = 0;
      else if (accept || rdFall) mIntN = 1;
      if (wrEnd) begin
        mCnt = busIn[1:0]; mBank = busIn[2]; mPd = busIn[3];
      end
      pWr = wrAct; pRd = rdAct; pCnv = cnvN;
    end
    #2;
    if (rstN) begin
      chk("R7 intN", intN, mIntN);
      chk("R4 holdOut", holdOut, mHold);
      chk("R10 pwrDown", pwrDown, mPd);
      chk("R9 busOe", busOe, (!csN && !rdN) ? 1 : 0);
      if (busOe && valid[mPtr]) chk("R8 busOut", busOut, res[mPtr]);
      if (mHold) begin
        chk("R3 bankSel", bankSel, seqBank);
        chk("R3 chanSel", chanSel, (seqN*CONV - busyLeft) / CONV);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeWord(logic [3:0] w);
    csN = 0; wrN = 0; busIn = w; tick();
    wrN = 1; tick();
    csN = 1; tick();
  endtask

  task automatic readWord(output int v);
    csN = 0; rdN = 0; tick();
    v = busOut;
    rdN = 1; tick();
    csN = 1;
  endtask

  // start and count hold cycles; optional extra start mid-run
  task automatic runSeq(int n, bit extraStart, string tag);
    int cyc;
    cnvN = 0; tick();
    cnvN = 1; tick();
    cyc = 0;
    while (holdOut === 1'b1 && cyc < 1000) begin
      cyc++;
      if (extraStart && cyc == 10) cnvN = 0;
      if (extraStart && cyc == 11) cnvN = 1;
      tick();
    end
    chk(tag, cyc, n * CONV);
    chk("R4 intN low at end", intN, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R4 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    analog[0] = 'h000; analog[1] = 'hFFF; analog[2] = 'h800; analog[3] = 'h123;
    analog[4] = 'h7FF; analog[5] = 'h001; analog[6] = 'hABC; analog[7] = 'h555;
    tick(3);
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 intN", intN, 1);
    chk("R1 holdOut", holdOut, 0);
    chk("R1 busOe", busOe, 0);
    chk("R1 pwrDown", pwrDown, 0);

    // R1 default mode: single channel bank A
    runSeq(1, 0, "R1 default length");
    readWord(v); chk("R6 ch1 min code", v, 'h800);
    chk("R7 intN released", intN, 1);

    // R2 program four channels bank A, R5 extra start ignored
    writeWord(4'b0011);
    runSeq(4, 1, "R5 length with extra start");
    readWord(v); chk("R6 ch1", v, 'h800);
    readWord(v); chk("R6 ch2 max", v, 'h7FF);
    readWord(v); chk("R6 ch3 zero", v, 'h000);
    readWord(v); chk("R6 ch4", v, 'h923);
    readWord(v); chk("R8 wrap to ch1", v, 'h800);

    // R2 bank B three channels
    writeWord(4'b0110);
    runSeq(3, 0, "R2 three channels");
    readWord(v); chk("R2 bank B ch1", v, 'hFFF);
    readWord(v); chk("R2 bank B ch2", v, 'h801);
    readWord(v); chk("R2 bank B ch3", v, 'h2BC);
    readWord(v); chk("R8 ch4 keeps old", v, 'h923);

    // R9 write and read with CS high are ignored
    csN = 1; wrN = 0; busIn = 4'b1000; tick(); wrN = 1; tick();
    chk("R9 write ignored", pwrDown, 0);
    rdN = 0; tick(); chk("R9 no drive", busOe, 0); rdN = 1; tick();
    readWord(v); chk("R9 ptr unchanged", v, 'hFFF);

    // R10 power-down
    writeWord(4'b1000);
    chk("R10 pwrDown set", pwrDown, 1);
    cnvN = 0; tick(); cnvN = 1; tick(2);
    chk("R10 start ignored", holdOut, 0);
    writeWord(4'b0001);
    chk("R10 woken", pwrDown, 0);
    runSeq(2, 0, "R10 wake mode length");

    // R8 read end and start in the same clock
    readWord(v);
    csN = 0; rdN = 0; cnvN = 0; tick();
    rdN = 1; cnvN = 1; tick();
    csN = 1;
    while (holdOut === 1'b1) tick();
    readWord(v); chk("R8 start beats advance", v, 'h800);

    // R11 read begins on the final clock of a sequence
    cnvN = 0; tick(); cnvN = 1; tick();
    while (busyLeft != 1) tick();
    csN = 0; rdN = 0; tick();
    chk("R11 end beats read", intN, 0);
    rdN = 1; tick(); csN = 1; tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule